// File: doc/BRIEF.md
# Monochrome-to-Color Expansion Writer

This block sits between the host write path and the framebuffer write port of a display controller. It takes one host byte at a time together with its byte address. When expansion is enabled, it treats that byte as a monochrome bitmap. Each bitmap bit becomes a pixel that takes either a programmed foreground color (bit set) or a programmed background color (bit clear). When expansion is disabled, the host byte is written through unchanged.

Three small registers are written and read through a simple register port: the foreground color, the background color and a control byte. Control bit 0 turns expansion on. Control bit 1 chooses how the bitmap is expanded:

- With bit 1 clear, the block uses 16-color expansion. It produces eight 4-bit pixels.
- With bit 1 set, the block uses 256-color nibble expansion. It produces four 8-bit pixels.

The result is a 32-bit pixel word with a byte write strobe, presented one cycle after the host write.

Top module: `cexp_writer`

## Requirements
- R1: After reset, all three registers read 0, `pix_valid_o` is low and `pix_strb_o` is 0.
- R2: Register address 0 holds the foreground color, address 1 the background color and address 2 the control byte. All 8 bits of each register read back as last written. Address 3 reads 0 and ignores writes.
- R3: When control bit 0 is clear, the host byte passes through unchanged, whatever the value of bit 1. It appears on byte lane `host_addr_i[1:0]` of `pix_data_o`, where lane k is bits [8k+7:8k]. Only that lane's strobe bit is set, and `pix_addr_o` is the host address with its low two bits cleared.
- R4: When control bits [1:0] are 01, the block expands all 8 host bits into eight 4-bit pixels. Each pixel is the low nibble of the foreground register if its bit is 1, or the low nibble of the background register if its bit is 0. Bits 7:4 of both color registers have no effect. Host bit 7 is the leftmost pixel and goes to lane 0 bits [7:4]. Host bit 6 goes to lane 0 bits [3:0], host bit 5 to lane 1 bits [7:4], and so on down to host bit 0 in lane 3 bits [3:0].
- R5: When control bits [1:0] are 11, only host bits 7:4 are used. They become four 8-bit pixels with full 8-bit foreground or background colors. Host bit 7 goes to lane 0 and host bit 4 to lane 3. Host bits 3:0 have no effect.
- R6: In either expansion mode, `pix_strb_o` is 4'b1111 and `pix_addr_o` equals the host address times 4. This includes the largest host address.
- R7: `pix_valid_o` is high in exactly the cycle after each cycle with `host_we_i` high, and low otherwise. While it is low, `pix_strb_o` is 0.
- R8: A register write in the same cycle as a host write does not affect that host write. The register takes effect from the next host write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| host_we_i | input | 1 | Host byte write strobe |
| host_addr_i | input | ADDR_W | Host byte address |
| host_data_i | input | 8 | Host byte (bitmap or pixel) |
| pix_valid_o | output | 1 | Framebuffer write valid |
| pix_addr_o | output | ADDR_W+2 | Framebuffer byte address of lane 0 |
| pix_data_o | output | 32 | Pixel word, lane k at bits [8k+7:8k] |
| pix_strb_o | output | 4 | Byte lane write strobes |

## Verification
The bench uses several kinds of bitmap bytes:
- Mixed bitmaps with asymmetric bit patterns such as 0xB4. These expose a reversed or shifted pixel order and a swapped foreground/background choice.
- All-ones and all-zero nibbles. These show whether the full color value or only the low nibble is used.
- Two bytes that differ only in their low nibble, sent in 256-color mode. They must give the same result, which proves those bits are ignored.

Pass-through writes go to several lane offsets and also with control bit 1 set alone, which separates the role of bit 0 from bit 1. A register write that lands in the same cycle as a host write shows whether the old or the new color is used.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
  localparam int unsigned PIX_BYTES = 4;
  localparam int unsigned LANE_AW   = $clog2(PIX_BYTES);

  localparam logic [1:0] REG_FG   = 2'd0;
  localparam logic [1:0] REG_BG   = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_NIB16 = 2'd1,
    MODE_BYTE8 = 2'd2
  } cexp_mode_e;

  function automatic cexp_mode_e decode_mode(input logic [1:0] ctrl);
    if (!ctrl[0])     return MODE_PASS;
    else if (ctrl[1]) return MODE_BYTE8;
    else              return MODE_NIB16;
  endfunction
endpackage

// File: rtl/cexp_regs.sv
module cexp_regs
  import cexp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [7:0] fg_o,
  output logic [7:0] bg_o,
  output logic [7:0] ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fg_o   <= '0;
      bg_o   <= '0;
      ctrl_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_FG:   fg_o   <= wdata_i;
        REG_BG:   bg_o   <= wdata_i;
        REG_CTRL: ctrl_o <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      REG_FG:   rdata_o = fg_o;
      REG_BG:   rdata_o = bg_o;
      REG_CTRL: rdata_o = ctrl_o;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cexp_expand.sv
module cexp_expand
  import cexp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned OUT_AW = ADDR_W + LANE_AW,
  localparam int unsigned DW     = 8 * PIX_BYTES
) (
  input  cexp_mode_e          mode_i,
  input  logic [7:0]          fg_i,
  input  logic [7:0]          bg_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          data_i,
  output logic [OUT_AW-1:0]   addr_o,
  output logic [DW-1:0]       data_o,
  output logic [PIX_BYTES-1:0] strb_o
);
  localparam int unsigned NIB_PIX = 2 * PIX_BYTES;

  logic [DW-1:0] nib_word, byte_word, pass_word;
  logic [PIX_BYTES-1:0] pass_strb;
  logic [LANE_AW-1:0] lane;

  assign lane = addr_i[LANE_AW-1:0];

  // pixel k: leftmost = host bit 7; even k in the high nibble of lane k/2
  for (genvar k = 0; k < NIB_PIX; k++) begin : g_nib
    localparam int unsigned POS = 8 * (k / 2) + ((k % 2) != 0 ? 0 : 4);
    assign nib_word[POS +: 4] = data_i[7 - k] ? fg_i[3:0] : bg_i[3:0];
  end

  for (genvar k = 0; k < PIX_BYTES; k++) begin : g_byte
    assign byte_word[8*k +: 8] = data_i[7 - k] ? fg_i : bg_i;
    assign pass_word[8*k +: 8] = data_i;
    assign pass_strb[k]        = (lane == LANE_AW'(k));
  end

  always_comb begin
    case (mode_i)
      MODE_NIB16: begin
        data_o = nib_word;
        strb_o = '1;
        addr_o = {addr_i, {LANE_AW{1'b0}}};
      end
      MODE_BYTE8: begin
        data_o = byte_word;
        strb_o = '1;
        addr_o = {addr_i, {LANE_AW{1'b0}}};
      end
      default: begin
        data_o = pass_word;
        strb_o = pass_strb;
        addr_o = {{LANE_AW{1'b0}}, addr_i[ADDR_W-1:LANE_AW], {LANE_AW{1'b0}}};
      end
    endcase
  end
endmodule

// File: rtl/cexp_out_stage.sv
module cexp_out_stage
  import cexp_pkg::*;
#(
  parameter int unsigned OUT_AW = 18,
  localparam int unsigned DW = 8 * PIX_BYTES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [OUT_AW-1:0]    addr_i,
  input  logic [DW-1:0]        data_i,
  input  logic [PIX_BYTES-1:0] strb_i,
  output logic                 valid_o,
  output logic [OUT_AW-1:0]    addr_o,
  output logic [DW-1:0]        data_o,
  output logic [PIX_BYTES-1:0] strb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
      strb_o  <= '0;
    end else begin
      valid_o <= valid_i;
      strb_o  <= valid_i ? strb_i : '0;
      if (valid_i) begin
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/cexp_writer.sv
module cexp_writer
  import cexp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned OUT_AW = ADDR_W + LANE_AW,
  localparam int unsigned DW     = 8 * PIX_BYTES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_addr_i,
  input  logic [7:0]           reg_wdata_i,
  output logic [7:0]           reg_rdata_o,
  input  logic                 host_we_i,
  input  logic [ADDR_W-1:0]    host_addr_i,
  input  logic [7:0]           host_data_i,
  output logic                 pix_valid_o,
  output logic [OUT_AW-1:0]    pix_addr_o,
  output logic [DW-1:0]        pix_data_o,
  output logic [PIX_BYTES-1:0] pix_strb_o
);
  logic [7:0] fg_q, bg_q, ctrl_q;
  cexp_mode_e mode;
  logic [OUT_AW-1:0]    exp_addr;
  logic [DW-1:0]        exp_data;
  logic [PIX_BYTES-1:0] exp_strb;

  cexp_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .fg_o    (fg_q),
    .bg_o    (bg_q),
    .ctrl_o  (ctrl_q)
  );

  assign mode = decode_mode(ctrl_q[1:0]);

  cexp_expand #(.ADDR_W(ADDR_W)) u_expand (
    .mode_i (mode),
    .fg_i   (fg_q),
    .bg_i   (bg_q),
    .addr_i (host_addr_i),
    .data_i (host_data_i),
    .addr_o (exp_addr),
    .data_o (exp_data),
    .strb_o (exp_strb)
  );

  cexp_out_stage #(.OUT_AW(OUT_AW)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (host_we_i),
    .addr_i  (exp_addr),
    .data_i  (exp_data),
    .strb_i  (exp_strb),
    .valid_o (pix_valid_o),
    .addr_o  (pix_addr_o),
    .data_o  (pix_data_o),
    .strb_o  (pix_strb_o)
  );
endmodule

// File: rtl/cexp_writer_chk.sv
module cexp_writer_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        fg_i,
  input logic [7:0]        bg_i,
  input logic [7:0]        ctrl_i,
  input logic              host_we_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic [7:0]        host_data_i,
  input logic              pix_valid_o,
  input logic [ADDR_W+1:0] pix_addr_o,
  input logic [31:0]       pix_data_o,
  input logic [3:0]        pix_strb_o
);
  assert_fg_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 2'd0 |=> fg_i == $past(reg_wdata_i));
  assert_ctrl_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 2'd2 |=> ctrl_i == $past(reg_wdata_i));
  assert_pass_one_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !$past(ctrl_i[0]) |-> $countones(pix_strb_o) == 1);
  assert_nib_all_fg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && $past(ctrl_i[1:0]) == 2'b01 && $past(host_data_i) == 8'hFF
      |-> pix_data_o == {8{$past(fg_i[3:0])}});
  assert_byte_all_bg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && $past(ctrl_i[1:0]) == 2'b11 && $past(host_data_i[7:4]) == 4'h0
      |-> pix_data_o == {4{$past(bg_i)}});
  assert_exp_addr_strb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && $past(ctrl_i[0])
      |-> pix_strb_o == 4'hF && pix_addr_o == {$past(host_addr_i), 2'b00});
  assert_valid_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i |=> pix_valid_o);
  assert_valid_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_we_i |=> !pix_valid_o);
  assert_strb_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> pix_strb_o == 4'h0);
endmodule

bind cexp_writer cexp_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .fg_i        (fg_q),
  .bg_i        (bg_q),
  .ctrl_i      (ctrl_q),
  .host_we_i   (host_we_i),
  .host_addr_i (host_addr_i),
  .host_data_i (host_data_i),
  .pix_valid_o (pix_valid_o),
  .pix_addr_o  (pix_addr_o),
  .pix_data_o  (pix_data_o),
  .pix_strb_o  (pix_strb_o)
);

// File: tb/cexp_writer_bench.sv
module cexp_writer_bench;
  localparam int unsigned AW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0]  host_data = '0;
  logic        pix_valid;
  logic [AW+1:0] pix_addr;
  logic [31:0] pix_data;
  logic [3:0]  pix_strb;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  cexp_writer #(.ADDR_W(AW)) u_cexp_writer (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_data_i(host_data),
    .pix_valid_o(pix_valid), .pix_addr_o(pix_addr),
    .pix_data_o(pix_data), .pix_strb_o(pix_strb)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_nib(input logic [7:0] d, input logic [7:0] fg,
                                            input logic [7:0] bg);
    logic [31:0] w = '0;
    for (int p = 0; p < 8; p++) begin
      logic [3:0] c = d[7-p] ? fg[3:0] : bg[3:0];
      if (p % 2 == 0) w[8*(p/2)+4 +: 4] = c;
      else            w[8*(p/2) +: 4]   = c;
    end
    return w;
  endfunction

  function automatic logic [31:0] model_byte(input logic [7:0] d, input logic [7:0] fg,
                                             input logic [7:0] bg);
    logic [31:0] w = '0;
    for (int p = 0; p < 4; p++) w[8*p +: 8] = d[7-p] ? fg : bg;
    return w;
  endfunction

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, 64'(reg_rdata), 64'(exp));
  endtask

  // drive at a falling edge; outputs are sampled at the next falling edge
  task automatic host_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid", 64'(pix_valid), 64'd0);
    check("R1 strb", 64'(pix_strb), 64'd0);
    reg_rd_check("R1 fg", 2'd0, 8'h00);
    reg_rd_check("R1 bg", 2'd1, 8'h00);
    reg_rd_check("R1 ctrl", 2'd2, 8'h00);
  endtask

  task automatic t_regs;
    reg_wr(2'd0, 8'hA5);
    reg_wr(2'd1, 8'h3C);
    reg_wr(2'd2, 8'hC0);
    reg_wr(2'd3, 8'hFF);
    reg_rd_check("R2 fg", 2'd0, 8'hA5);
    reg_rd_check("R2 bg", 2'd1, 8'h3C);
    reg_rd_check("R2 ctrl", 2'd2, 8'hC0);
    reg_rd_check("R2 addr3", 2'd3, 8'h00);
  endtask

  task automatic t_pass;
    reg_wr(2'd2, 8'h00);
    host_wr(16'h0005, 8'h9E);
    check("R3 data", 64'(pix_data[15:8]), 64'h9E);
    check("R3 strb", 64'(pix_strb), 64'b0010);
    check("R3 addr", 64'(pix_addr), 64'h0004);
    reg_wr(2'd2, 8'h02);
    host_wr(16'h1233, 8'h41);
    check("R3 bit1 only data", 64'(pix_data[31:24]), 64'h41);
    check("R3 bit1 only strb", 64'(pix_strb), 64'b1000);
    check("R3 bit1 only addr", 64'(pix_addr), 64'h1230);
    host_wr(16'h0000, 8'h7C);
    check("R3 lane0", 64'(pix_data[7:0]), 64'h7C);
    check("R3 lane0 strb", 64'(pix_strb), 64'b0001);
  endtask

  task automatic t_nib16;
    reg_wr(2'd0, 8'hA7);
    reg_wr(2'd1, 8'h52);
    reg_wr(2'd2, 8'h01);
    host_wr(16'h0010, 8'hB4);
    check("R4 mixed", 64'(pix_data), 64'(model_nib(8'hB4, 8'hA7, 8'h52)));
    check("R4 mixed literal", 64'(pix_data), 64'h22277772);
    check("R6 nib addr", 64'(pix_addr), 64'h40);
    check("R6 nib strb", 64'(pix_strb), 64'hF);
    host_wr(16'h0011, 8'hFF);
    check("R4 all fg low nibble", 64'(pix_data), 64'h77777777);
    host_wr(16'h0012, 8'h00);
    check("R4 all bg low nibble", 64'(pix_data), 64'h22222222);
  endtask

  task automatic t_byte8;
    reg_wr(2'd0, 8'hE1);
    reg_wr(2'd1, 8'h1E);
    reg_wr(2'd2, 8'h03);
    host_wr(16'h0100, 8'h6F);
    check("R5 mixed", 64'(pix_data), 64'(model_byte(8'h6F, 8'hE1, 8'h1E)));
    check("R5 mixed literal", 64'(pix_data), 64'h1EE1E11E);
    host_wr(16'h0100, 8'h60);
    check("R5 low nibble ignored", 64'(pix_data), 64'h1EE1E11E);
    host_wr(16'hFFFF, 8'h90);
    check("R5 ends", 64'(pix_data), 64'hE11E1EE1);
    check("R6 max addr", 64'(pix_addr), 64'h3FFFC);
    check("R6 byte strb", 64'(pix_strb), 64'hF);
  endtask

  task automatic t_timing;
    host_wr(16'h0020, 8'hAA);
    check("R7 valid after write", 64'(pix_valid), 64'd1);
    @(negedge clk);
    check("R7 valid drops", 64'(pix_valid), 64'd0);
    check("R7 idle strb", 64'(pix_strb), 64'd0);
  endtask

  task automatic t_same_cycle;
    // ctrl 03, fg E1, bg 1E
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h44;
    host_we = 1'b1; host_addr = 16'h0030; host_data = 8'hF0;
    @(negedge clk);
    reg_we = 1'b0; host_we = 1'b0;
    check("R8 old fg used", 64'(pix_data), 64'hE1E1E1E1);
    host_wr(16'h0031, 8'hF0);
    check("R8 new fg used", 64'(pix_data), 64'h44444444);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_regs;
    t_pass;
    t_nib16;
    t_byte8;
    t_timing;
    t_same_cycle;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule